// File: doc/BRIEF.md
# Host-Driven Buffer DMA Engine

This block moves bytes between a host data port and a local buffer memory. It works under direct control of the host. Through an eight-bit register port the host loads:

- a start address and a byte count, each 16 bits wide and written as a low byte and a high byte;
- a configuration byte.

The host then writes a three-bit command. A read command fetches bytes from memory and hands them to the host one transfer at a time. A write command takes bytes offered by the host and stores them in memory.

There is a single working address register and a single working count register. A transfer moves forward by advancing the address and reducing the count, so the host can read progress at any moment. When the count reaches zero the engine goes idle and sets a completion flag. That flag raises the interrupt output when its mask bit is set.

An abort command stops the engine at once. It leaves the address at the point where the transfer stopped, and the host is expected to clear the count afterwards. The configuration selects byte or 16-bit word transfers, and the order in which the two bytes of a word reach the host.

Top module: `rdma_engine`

## Requirements
- R1: After reset, every readable register returns zero, and `busy`, `irq`, `host_wr_ready` and `host_rd_valid` are low.
- R2: While idle, register offsets 1/2 load the low and high bytes of the address. Offsets 3/4 do the same for the count. Offset 5 loads the configuration: bit0 selects word mode, bit1 swaps byte order, bit2 is the interrupt mask. Reading any of these offsets returns the current value.
- R3: Command code 1 or 3, written to offset 0 bits [2:0], runs a read in byte mode. Each transfer reads the byte at the current address from byte lane `addr[0]` and delivers it on `host_rd_data[7:0]` with the upper byte zero. After each transfer the address rises by 1 and the count falls by 1.
- R4: Command code 2 runs a write. Each accepted host byte is stored at the current address. `mem_be` is 01 for an even address and 10 for an odd one, and the byte appears on both lanes of `mem_wdata`.
- R5: In word mode, a transfer moves two bytes with `mem_be` 11 when the address is even and at least two bytes remain, and the address and count step by 2. Otherwise the transfer moves a single byte as in byte mode.
- R6: With the swap bit clear, a word keeps its memory layout: the lower address goes in the low byte. With the swap bit set, the two bytes are exchanged in both directions.
- R7: When the count reaches zero, the engine goes idle and sets status bit0 (offset 6). `irq` equals that flag ANDed with the mask bit. Writing 1 to status bit0 clears the flag.
- R8: A read or write command issued with a count of zero finishes with the flag set and no memory cycle.
- R9: A command with bit2 set aborts at once. No further memory cycle follows, the address and count keep the values they had reached, and the completion flag is not set.
- R10: Command code 0 is ignored. A non-abort command written while busy is ignored, and the running operation continues.
- R11: No memory read is issued while `host_rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| host_wr_valid | input | 1 | Host offers write data |
| host_wr_data | input | 16 | Host write data |
| host_wr_ready | output | 1 | Engine accepts write data |
| host_rd_ready | input | 1 | Host can take read data |
| host_rd_valid | output | 1 | Read data valid (one cycle) |
| host_rd_data | output | 16 | Read data to host |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rvalid | input | 1 | Memory read data returned |
| busy | output | 1 | An operation is running |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench builds the engine with its default 16-bit address and count. It therefore drives full low/high register splits, odd start addresses and odd counts, which bring within reach both the single-byte head of a word transfer and its single-byte tail. A memory model with one cycle of latency makes the outstanding-read tracking and the host flow control visible. Word mode with the swap bit set is exercised in both directions, and an abort arrives in the middle of a word write.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam logic [2:0] REG_CMD     = 3'd0;
    localparam logic [2:0] REG_ADDR_LO = 3'd1;
    localparam logic [2:0] REG_ADDR_HI = 3'd2;
    localparam logic [2:0] REG_CNT_LO  = 3'd3;
    localparam logic [2:0] REG_CNT_HI  = 3'd4;
    localparam logic [2:0] REG_CFG     = 3'd5;
    localparam logic [2:0] REG_STAT    = 3'd6;
endpackage

// File: rtl/rdma_cmd_decode.sv
module rdma_cmd_decode
    import rdma_pkg::*;
(
    input  logic [2:0] code,
    output logic       is_abort,
    output op_e        start_op
);
    always_comb begin
        is_abort = code[2];
        case (code[1:0])
            2'b01, 2'b11: start_op = OP_READ;
            2'b10:        start_op = OP_WRITE;
            default:      start_op = OP_IDLE;
        endcase
        if (code[2]) start_op = OP_IDLE;
    end
endmodule

// File: rtl/rdma_step.sv
module rdma_step #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wide,
    output logic [1:0]        be,
    output logic [1:0]        len
);
    logic two;
    always_comb begin
        two = wide && !addr[0] && (cnt > CNT_W'(1));
        len = two ? 2'd2 : 2'd1;
        if (two)          be = 2'b11;
        else if (addr[0]) be = 2'b10;
        else              be = 2'b01;
    end
endmodule

// File: rtl/rdma_lane_fmt.sv
module rdma_lane_fmt (
    input  logic        swap,
    input  logic [1:0]  rd_be,
    input  logic [15:0] mem_rdata,
    output logic [15:0] host_rdata,
    input  logic [1:0]  wr_be,
    input  logic [15:0] host_wdata,
    output logic [15:0] mem_wdata
);
    localparam int LANES = 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mem_wdata[8*i +: 8] = (wr_be == 2'b11)
            ? (swap ? host_wdata[8*(LANES-1-i) +: 8] : host_wdata[8*i +: 8])
            : host_wdata[7:0];
    end

    always_comb begin
        if (rd_be == 2'b11)
            host_rdata = swap ? {mem_rdata[7:0], mem_rdata[15:8]} : mem_rdata;
        else if (rd_be[1])
            host_rdata = {8'h00, mem_rdata[15:8]};
        else
            host_rdata = {8'h00, mem_rdata[7:0]};
    end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              host_wr_valid,
    input  logic [15:0]       host_wr_data,
    output logic              host_wr_ready,
    input  logic              host_rd_ready,
    output logic              host_rd_valid,
    output logic [15:0]       host_rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_rvalid,
    output logic              busy,
    output logic              irq
);
    localparam int AHI = ADDR_W - 8;
    localparam int CHI = CNT_W - 8;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              wide;
        logic              swap;
        logic              mask;
        logic              done;
        logic              outst;
        logic              discard;
        logic              mreq;
        logic              mwe;
        logic [ADDR_W-1:0] maddr;
        logic [1:0]        mbe;
        logic [1:0]        rdbe;
        logic [15:0]       mwdata;
        logic              rvld;
        logic [15:0]       rdata;
    } state_t;

    state_t st_q, st_d;

    logic        is_abort;
    op_e         start_op;
    logic [1:0]  step_be;
    logic [1:0]  step_len;
    logic [15:0] fmt_rdata;
    logic [15:0] fmt_wdata;

    rdma_cmd_decode u_dec (
        .code     (reg_wdata[2:0]),
        .is_abort (is_abort),
        .start_op (start_op)
    );

    rdma_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
        .addr (st_q.addr),
        .cnt  (st_q.cnt),
        .wide (st_q.wide),
        .be   (step_be),
        .len  (step_len)
    );

    rdma_lane_fmt u_fmt (
        .swap       (st_q.swap),
        .rd_be      (st_q.rdbe),
        .mem_rdata  (mem_rdata),
        .host_rdata (fmt_rdata),
        .wr_be      (step_be),
        .host_wdata (host_wr_data),
        .mem_wdata  (fmt_wdata)
    );

    logic cmd_wr, abort_now, rd_issue, wr_take;

    always_comb begin
        st_d      = st_q;
        st_d.mreq = 1'b0;
        st_d.rvld = 1'b0;

        cmd_wr    = reg_wr && (reg_addr == REG_CMD);
        abort_now = cmd_wr && is_abort;

        // set-up registers change only while idle
        if (reg_wr && st_q.op == OP_IDLE) begin
            case (reg_addr)
                REG_ADDR_LO: st_d.addr[7:0]        = reg_wdata;
                REG_ADDR_HI: st_d.addr[ADDR_W-1:8] = reg_wdata[AHI-1:0];
                REG_CNT_LO:  st_d.cnt[7:0]         = reg_wdata;
                REG_CNT_HI:  st_d.cnt[CNT_W-1:8]   = reg_wdata[CHI-1:0];
                REG_CFG: begin
                    st_d.wide = reg_wdata[0];
                    st_d.swap = reg_wdata[1];
                    st_d.mask = reg_wdata[2];
                end
                default: ;
            endcase
        end
        if (reg_wr && reg_addr == REG_STAT && reg_wdata[0]) st_d.done = 1'b0;

        // returning read data
        if (mem_rvalid) begin
            st_d.outst   = 1'b0;
            st_d.discard = 1'b0;
            if (!st_q.discard) begin
                st_d.rvld  = 1'b1;
                st_d.rdata = fmt_rdata;
            end
        end

        rd_issue = (st_q.op == OP_READ) && (st_q.cnt != '0) && !st_q.outst
                   && host_rd_ready && !abort_now;
        wr_take  = host_wr_valid && host_wr_ready && !abort_now;

        if (rd_issue || wr_take) begin
            st_d.mreq  = 1'b1;
            st_d.mwe   = wr_take;
            st_d.maddr = st_q.addr;
            st_d.mbe   = step_be;
            st_d.addr  = st_q.addr + ADDR_W'(step_len);
            st_d.cnt   = st_q.cnt - CNT_W'(step_len);
        end
        if (rd_issue) begin
            st_d.outst = 1'b1;
            st_d.rdbe  = step_be;
        end
        if (wr_take) st_d.mwdata = fmt_wdata;

        // completion once nothing is left in flight
        if (st_q.op != OP_IDLE && st_q.cnt == '0 && !st_q.outst && !abort_now) begin
            st_d.op   = OP_IDLE;
            st_d.done = 1'b1;
        end

        if (abort_now) begin
            st_d.op      = OP_IDLE;
            st_d.discard = st_d.outst;
        end else if (cmd_wr && st_q.op == OP_IDLE && start_op != OP_IDLE) begin
            st_d.op = start_op;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            REG_CMD:     reg_rdata = {7'b0, st_q.op != OP_IDLE};
            REG_ADDR_LO: reg_rdata = st_q.addr[7:0];
            REG_ADDR_HI: reg_rdata = 8'(st_q.addr >> 8);
            REG_CNT_LO:  reg_rdata = st_q.cnt[7:0];
            REG_CNT_HI:  reg_rdata = 8'(st_q.cnt >> 8);
            REG_CFG:     reg_rdata = {5'b0, st_q.mask, st_q.swap, st_q.wide};
            REG_STAT:    reg_rdata = {7'b0, st_q.done};
            default:     reg_rdata = 8'h00;
        endcase
    end

    assign busy          = st_q.op != OP_IDLE;
    assign irq           = st_q.done && st_q.mask;
    assign host_wr_ready = (st_q.op == OP_WRITE) && (st_q.cnt != '0);
    assign host_rd_valid = st_q.rvld;
    assign host_rd_data  = st_q.rdata;
    assign mem_req       = st_q.mreq;
    assign mem_we        = st_q.mwe;
    assign mem_addr      = st_q.maddr;
    assign mem_be        = st_q.mbe;
    assign mem_wdata     = st_q.mwdata;
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              host_wr_valid,
    input logic              host_wr_ready,
    input logic              host_rd_ready,
    input logic              host_rd_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_be,
    input logic              mem_rvalid,
    input logic              busy,
    input logic              done_flag
);
    logic abort_cmd;
    assign abort_cmd = reg_wr && reg_addr == 3'd0 && reg_wdata[2];

    // R9
    abort_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_cmd |=> (!busy && !mem_req));

    // R3
    rd_follows_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_valid |-> $past(mem_rvalid));

    // R4
    write_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_valid && host_wr_ready && !abort_cmd) |=> (mem_req && mem_we));

    // R5
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == 2'b11) |-> !mem_addr[0]);

    // R7
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort_cmd)) |-> done_flag);

    // R10
    illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr && reg_addr == 3'd0 && reg_wdata[2:0] == 3'd0) |=> !busy);

    // R11
    rd_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> $past(host_rd_ready));
endmodule

bind rdma_engine rdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .host_wr_valid (host_wr_valid),
    .host_wr_ready (host_wr_ready),
    .host_rd_ready (host_rd_ready),
    .host_rd_valid (host_rd_valid),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .mem_rvalid    (mem_rvalid),
    .busy          (busy),
    .done_flag     (st_q.done)
);

// File: tb/rdma_engine_bench.sv
`timescale 1ns/1ps
module rdma_engine_bench;
    localparam int AW = 16;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        host_wr_valid = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        host_wr_ready;
    logic        host_rd_ready = 1'b1;
    logic        host_rd_valid;
    logic [15:0] host_rd_data;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rvalid;
    logic        busy, irq;

    always #2 clk = ~clk;

    rdma_engine #(.ADDR_W(AW), .CNT_W(CW)) u_rdma_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data), .host_wr_ready(host_wr_ready),
        .host_rd_ready(host_rd_ready), .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .busy(busy), .irq(irq)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] * 8'd13 + 8'd5;
    endfunction

    // memory model: one cycle read latency, contents given by pat()
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !mem_we;
            mem_rdata  <= {pat(mem_addr | 16'h1), pat(mem_addr & 16'hFFFE)};
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int n_memrd = 0;
    logic [15:0] exp_rd[$];
    string       exp_rd_tag[$];
    logic [33:0] exp_wr[$];
    string       exp_wr_tag[$];

    task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && !mem_we) n_memrd++;
            if (host_rd_valid) begin
                if (exp_rd.size() == 0) chk(1'b0, "R3 unexpected host read", 34'(host_rd_data), 34'h0);
                else begin
                    automatic logic [15:0] e = exp_rd.pop_front();
                    automatic string t = exp_rd_tag.pop_front();
                    chk(host_rd_data == e, t, 34'(host_rd_data), 34'(e));
                end
            end
            if (mem_req && mem_we) begin
                if (exp_wr.size() == 0) chk(1'b0, "R4 unexpected memory write", {mem_addr, mem_be, mem_wdata}, 34'h0);
                else begin
                    automatic logic [33:0] e = exp_wr.pop_front();
                    automatic string t = exp_wr_tag.pop_front();
                    chk({mem_addr, mem_be, mem_wdata} == e, t, {mem_addr, mem_be, mem_wdata}, e);
                end
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] c, input logic [7:0] cfg);
        reg_write(3'd1, a[7:0]);
        reg_write(3'd2, a[15:8]);
        reg_write(3'd3, c[7:0]);
        reg_write(3'd4, c[15:8]);
        reg_write(3'd5, cfg);
    endtask

    task automatic wait_done(input string req);
        logic [7:0] s;
        s = '0;
        for (int i = 0; i < 200 && !s[0]; i++) reg_read(3'd6, s);
        chk(s[0] == 1'b1, req, 34'(s), 34'h1);
    endtask

    task automatic host_push(input logic [15:0] d);
        @(negedge clk);
        while (!host_wr_ready) @(negedge clk);
        host_wr_valid = 1'b1; host_wr_data = d;
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic expect_rd(input logic [15:0] d, input string t);
        exp_rd.push_back(d); exp_rd_tag.push_back(t);
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d, input string t);
        exp_wr.push_back({a, be, d}); exp_wr_tag.push_back(t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int mr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 7; i++) begin
            reg_read(3'(i), r);
            chk(r == 8'h00, "R1 register reset value", 34'(r), 34'h0);
        end
        chk(!busy && !irq && !host_wr_ready && !host_rd_valid, "R1 outputs after reset",
            34'({busy, irq, host_wr_ready, host_rd_valid}), 34'h0);

        // R2 register readback
        setup(16'h1241, 16'h0203, 8'h00);
        reg_read(3'd2, r); chk(r == 8'h12, "R2 address high", 34'(r), 34'h12);
        reg_read(3'd4, r); chk(r == 8'h02, "R2 count high", 34'(r), 34'h02);
        reg_write(3'd2, 8'h00);
        reg_write(3'd4, 8'h00);

        // R3 byte read of 3 bytes from odd address 0x41
        expect_rd({8'h00, pat(16'h41)}, "R3 byte read 0x41");
        expect_rd({8'h00, pat(16'h42)}, "R3 byte read 0x42");
        expect_rd({8'h00, pat(16'h43)}, "R3 byte read 0x43");
        reg_write(3'd0, 8'h01);
        wait_done("R7 done after byte read");
        chk(exp_rd.size() == 0, "R3 all read bytes delivered", 34'(exp_rd.size()), 34'h0);
        reg_read(3'd1, r); chk(r == 8'h44, "R3 address advanced", 34'(r), 34'h44);
        reg_read(3'd3, r); chk(r == 8'h00, "R3 count reached zero", 34'(r), 34'h0);
        chk(!busy && !irq, "R7 idle, irq masked", 34'({busy, irq}), 34'h0);
        reg_write(3'd5, 8'h04);
        @(negedge clk); chk(irq == 1'b1, "R7 irq with mask set", 34'(irq), 34'h1);
        reg_write(3'd6, 8'h01);
        @(negedge clk); chk(irq == 1'b0, "R7 flag cleared", 34'(irq), 34'h0);
        reg_write(3'd5, 8'h00);

        // R3 code 3 acts as read
        setup(16'h0050, 16'h0002, 8'h00);
        expect_rd({8'h00, pat(16'h50)}, "R3 code3 read 0x50");
        expect_rd({8'h00, pat(16'h51)}, "R3 code3 read 0x51");
        reg_write(3'd0, 8'h03);
        wait_done("R3 code3 completes");
        chk(exp_rd.size() == 0, "R3 code3 bytes delivered", 34'(exp_rd.size()), 34'h0);
        reg_write(3'd6, 8'h01);

        // R4 byte write of 3 bytes at 0x80
        setup(16'h0080, 16'h0003, 8'h00);
        reg_write(3'd0, 8'h02);
        expect_wr(16'h0080, 2'b01, 16'h1111, "R4 byte write 0x80");
        host_push(16'hEE11);
        expect_wr(16'h0081, 2'b10, 16'h2222, "R4 byte write 0x81");
        host_push(16'hEE22);
        expect_wr(16'h0082, 2'b01, 16'h3333, "R4 byte write 0x82");
        host_push(16'hEE33);
        wait_done("R7 done after write");
        chk(exp_wr.size() == 0, "R4 all writes seen", 34'(exp_wr.size()), 34'h0);
        reg_write(3'd6, 8'h01);

        // R5 word read, odd count: two words then tail byte
        setup(16'h0020, 16'h0005, 8'h01);
        expect_rd({pat(16'h21), pat(16'h20)}, "R5 word read 0x20");
        expect_rd({pat(16'h23), pat(16'h22)}, "R5 word read 0x22");
        expect_rd({8'h00, pat(16'h24)}, "R5 tail byte 0x24");
        reg_write(3'd0, 8'h01);
        wait_done("R5 word read completes");
        chk(exp_rd.size() == 0, "R5 word reads delivered", 34'(exp_rd.size()), 34'h0);
        reg_read(3'd1, r); chk(r == 8'h25, "R5 address after word read", 34'(r), 34'h25);
        reg_write(3'd6, 8'h01);

        // R5 word write from odd address: head byte then word
        setup(16'h0091, 16'h0003, 8'h01);
        reg_write(3'd0, 8'h02);
        expect_wr(16'h0091, 2'b10, 16'h4545, "R5 head byte 0x91");
        host_push(16'h0045);
        expect_wr(16'h0092, 2'b11, 16'hBEEF, "R5 word write 0x92");
        host_push(16'hBEEF);
        wait_done("R5 word write completes");
        reg_write(3'd6, 8'h01);

        // R6 swapped byte order, read and write
        setup(16'h0030, 16'h0002, 8'h03);
        expect_rd({pat(16'h30), pat(16'h31)}, "R6 swapped read 0x30");
        reg_write(3'd0, 8'h01);
        wait_done("R6 swapped read completes");
        reg_write(3'd6, 8'h01);
        setup(16'h00C0, 16'h0002, 8'h03);
        reg_write(3'd0, 8'h02);
        expect_wr(16'h00C0, 2'b11, 16'h3412, "R6 swapped write 0xC0");
        host_push(16'h1234);
        wait_done("R6 swapped write completes");
        chk(exp_wr.size() == 0 && exp_rd.size() == 0, "R6 queues drained",
            34'(exp_wr.size() + exp_rd.size()), 34'h0);
        reg_write(3'd6, 8'h01);

        // R8 zero count
        setup(16'h0060, 16'h0000, 8'h00);
        mr = n_memrd;
        reg_write(3'd0, 8'h01);
        wait_done("R8 zero count completes");
        chk(n_memrd == mr, "R8 no memory cycle", 34'(n_memrd - mr), 34'h0);
        reg_write(3'd6, 8'h01);

        // R9 abort in the middle of a word write
        setup(16'h00A0, 16'h0008, 8'h01);
        reg_write(3'd0, 8'h02);
        expect_wr(16'h00A0, 2'b11, 16'h5101, "R9 write before abort");
        host_push(16'h5101);
        expect_wr(16'h00A2, 2'b11, 16'h5202, "R9 write before abort");
        host_push(16'h5202);
        reg_write(3'd0, 8'h04);
        repeat (4) @(negedge clk);
        chk(!busy && !host_wr_ready, "R9 engine stopped", 34'({busy, host_wr_ready}), 34'h0);
        reg_read(3'd1, r); chk(r == 8'hA4, "R9 address kept", 34'(r), 34'hA4);
        reg_read(3'd3, r); chk(r == 8'h04, "R9 count kept", 34'(r), 34'h04);
        reg_read(3'd6, r); chk(r == 8'h00, "R9 no completion flag", 34'(r), 34'h0);
        chk(exp_wr.size() == 0, "R9 writes before abort seen", 34'(exp_wr.size()), 34'h0);
        reg_write(3'd3, 8'h00);

        // R10 illegal code and command while busy
        reg_write(3'd0, 8'h00);
        reg_read(3'd0, r); chk(r == 8'h00, "R10 code 0 stays idle", 34'(r), 34'h0);
        setup(16'h00B0, 16'h0002, 8'h00);
        reg_write(3'd0, 8'h02);
        reg_write(3'd0, 8'h01);
        @(negedge clk);
        chk(busy && host_wr_ready, "R10 busy command ignored", 34'({busy, host_wr_ready}), 34'h3);
        expect_wr(16'h00B0, 2'b01, 16'h7777, "R10 write continues");
        host_push(16'h0077);
        expect_wr(16'h00B1, 2'b10, 16'h8888, "R10 write continues");
        host_push(16'h0088);
        wait_done("R10 write completes");
        reg_write(3'd6, 8'h01);

        // R11 host not ready holds reads back
        host_rd_ready = 1'b0;
        setup(16'h0010, 16'h0001, 8'h00);
        mr = n_memrd;
        reg_write(3'd0, 8'h01);
        repeat (10) @(negedge clk);
        chk(n_memrd == mr && busy, "R11 no read while host not ready", 34'(n_memrd - mr), 34'h0);
        expect_rd({8'h00, pat(16'h10)}, "R11 read after ready");
        host_rd_ready = 1'b1;
        wait_done("R11 read completes");
        chk(exp_rd.size() == 0, "R11 byte delivered", 34'(exp_rd.size()), 34'h0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule